// File: doc/BRIEF.md
# Debug Matchpoint Comparator Bank

This block holds eight hardware matchpoints for an on-chip debug unit. Each matchpoint owns a reference-value register and a configuration register, both written and read through a special-purpose-register (SPR) port. In every cycle, each armed matchpoint takes one quantity observed on the core's pipeline: the instruction fetch address, the load/store effective address, or the load/store data. It compares that quantity with its reference value using one of six relations. The relation is evaluated as either two's-complement or unsigned.

The result is a vector of match flags, one bit per matchpoint. The flags are registered. A flag is high for one cycle for each cycle in which the comparison holds and the selected source's valid strobe is high. Logic further down the debug unit, which is not part of this block, combines these flags into watchpoints.

Top module: `dbg_match_bank`

## Requirements
- R1: After a synchronous active-low reset, every reference and configuration register reads zero and the match vector is all zero.
- R2: Reference register i sits at SPR address 0x3000+i. A write stores the full 32-bit data word, and a read returns it. A write to a reference register leaves every configuration register unchanged.
- R3: Configuration register i sits at SPR address 0x3008+i. A read returns the stored low 8 bits, with bits 31:8 reading as zero. A write to a configuration register leaves every reference register unchanged.
- R4: A read from any address outside 0x3000–0x300F returns zero. A write to such an address changes no register.
- R5: Configuration bit 0 is the arm bit. A matchpoint whose arm bit is 0 never raises its match flag.
- R6: Configuration bits 7:5 choose the observed source: 1 fetch address, 2 load address, 3 store address, 4 load-or-store address, 5 load data, 6 store data, 7 load-or-store data. A match requires the valid strobe of the chosen source in the same cycle.
- R7: Configuration bits 3:1 choose the relation of the observed operand to the reference: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. When bit 4 is 0, the relation is evaluated as unsigned.
- R8: When configuration bit 4 is 1, the relation is evaluated on two's-complement values.
- R9: The match vector is registered. Conditions present before clock edge k appear on the output after edge k, and no earlier. The flag drops after the next edge once the condition is gone.
- R10: A relation code of 6 or 7, or a source code of 0, never raises the match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spr_we | input | 1 | SPR write enable |
| spr_addr | input | 16 | SPR address |
| spr_wdata | input | 32 | SPR write data |
| spr_rdata | output | 32 | SPR read data (combinational) |
| fetch_addr | input | 32 | Instruction fetch address |
| fetch_vld | input | 1 | Fetch address valid |
| ls_addr | input | 32 | Load/store effective address |
| ls_ld | input | 1 | Address valid, load access |
| ls_st | input | 1 | Address valid, store access |
| ls_data | input | 32 | Load/store data |
| ld_data_vld | input | 1 | Data valid, load |
| st_data_vld | input | 1 | Data valid, store |
| match_o | output | 8 | Registered match flags, one per matchpoint |

## Verification
The bench builds the block with its default parameters: eight matchpoints, 32-bit data and a 16-bit SPR address. With these values it can visit every reference and configuration address and the unmapped neighbours on both sides. Seven matchpoints can each be set to a different source in one pass, so strobe gating is checked for all source codes together. Six matchpoints can hold the six relations at once around a single reference value. The sign-bit boundary of a 32-bit word then separates signed from unsigned ordering.

// File: rtl/dbg_mp_pkg.sv
// Package: shared types for the debug matchpoint bank.
// Assumes an 8-bit configuration word laid out {sel, sgn, rel, arm}.
package dbg_mp_pkg;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_LT  = 3'd2,
        REL_LE  = 3'd3,
        REL_GT  = 3'd4,
        REL_GE  = 3'd5,
        REL_R6  = 3'd6,
        REL_R7  = 3'd7
    } mp_rel_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_FETCH = 3'd1,
        SRC_LDA   = 3'd2,
        SRC_STA   = 3'd3,
        SRC_LSA   = 3'd4,
        SRC_LDD   = 3'd5,
        SRC_STD   = 3'd6,
        SRC_LSD   = 3'd7
    } mp_src_e;

    typedef struct packed {
        mp_src_e sel;
        logic    sgn;
        mp_rel_e rel;
        logic    arm;
    } mp_cfg_t;

    localparam int CFG_W = $bits(mp_cfg_t);

endpackage

// File: rtl/dbg_mp_regfile.sv
// Module: reference and configuration registers for all matchpoints.
// Assumes single-cycle SPR writes and a combinational read path.
// Unmapped addresses read as zero and writes to them are dropped.
module dbg_mp_regfile
    import dbg_mp_pkg::*;
#(
    parameter int NUM_MP  = 8,
    parameter int DATA_W  = 32,
    parameter int SPR_AW  = 16,
    parameter int REF_BASE = 'h3000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spr_we,
    input  logic [SPR_AW-1:0]             spr_addr,
    input  logic [DATA_W-1:0]             spr_wdata,
    output logic [DATA_W-1:0]             spr_rdata,
    output logic [NUM_MP-1:0][DATA_W-1:0] ref_q,
    output mp_cfg_t [NUM_MP-1:0]          cfg_q
);
    localparam int CFG_BASE = REF_BASE + NUM_MP;

    logic [NUM_MP-1:0] ref_sel;
    logic [NUM_MP-1:0] cfg_sel;

    // Address decode: one select line per register.
    always_comb begin
        for (int i = 0; i < NUM_MP; i++) begin
            ref_sel[i] = (spr_addr == SPR_AW'(REF_BASE + i));
            cfg_sel[i] = (spr_addr == SPR_AW'(CFG_BASE + i));
        end
    end

    // Register update: reset clears, a write stores into the decoded register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            cfg_q <= '0;
        end else if (spr_we) begin
            for (int i = 0; i < NUM_MP; i++) begin
                if (ref_sel[i]) ref_q[i] <= spr_wdata;
                if (cfg_sel[i]) cfg_q[i] <= mp_cfg_t'(spr_wdata[CFG_W-1:0]);
            end
        end
    end

    // Read mux: stored value of the addressed register, zero elsewhere.
    always_comb begin
        spr_rdata = '0;
        for (int i = 0; i < NUM_MP; i++) begin
            if (ref_sel[i]) spr_rdata = ref_q[i];
            if (cfg_sel[i]) spr_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q[i]};
        end
    end

    AST_REF_WR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && |ref_sel) |=> $stable(cfg_q)); // R2
    AST_CFG_WR_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && |cfg_sel) |=> $stable(ref_q)); // R3
    AST_UNMAPPED_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && !(|ref_sel) && !(|cfg_sel)) |=> ($stable(ref_q) && $stable(cfg_q))); // R4

endmodule

// File: rtl/dbg_mp_compare.sv
// Module: one matchpoint's operand selection and relation test.
// Purely combinational; assumes the caller registers the hit.
// A reserved relation or source code yields no hit.
module dbg_mp_compare
    import dbg_mp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  mp_cfg_t           cfg,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [DATA_W-1:0] fetch_addr,
    input  logic              fetch_vld,
    input  logic [DATA_W-1:0] ls_addr,
    input  logic              ls_ld,
    input  logic              ls_st,
    input  logic [DATA_W-1:0] ls_data,
    input  logic              ld_data_vld,
    input  logic              st_data_vld,
    output logic              hit
);
    logic [DATA_W-1:0] opnd;
    logic              opnd_vld;
    logic              is_eq;
    logic              is_lt;
    logic              rel_ok;

    // Operand mux: chosen quantity and its strobe.
    always_comb begin
        opnd     = '0;
        opnd_vld = 1'b0;
        case (cfg.sel)
            SRC_FETCH: begin opnd = fetch_addr; opnd_vld = fetch_vld; end
            SRC_LDA:   begin opnd = ls_addr;    opnd_vld = ls_ld; end
            SRC_STA:   begin opnd = ls_addr;    opnd_vld = ls_st; end
            SRC_LSA:   begin opnd = ls_addr;    opnd_vld = ls_ld | ls_st; end
            SRC_LDD:   begin opnd = ls_data;    opnd_vld = ld_data_vld; end
            SRC_STD:   begin opnd = ls_data;    opnd_vld = st_data_vld; end
            SRC_LSD:   begin opnd = ls_data;    opnd_vld = ld_data_vld | st_data_vld; end
            default:   begin opnd = '0;         opnd_vld = 1'b0; end
        endcase
    end

    // Magnitude: shared equality and less-than, signedness per configuration.
    always_comb begin
        is_eq = (opnd == ref_val);
        if (cfg.sgn) is_lt = ($signed(opnd) < $signed(ref_val));
        else         is_lt = (opnd < ref_val);
    end

    // Relation decode from the shared primitives.
    always_comb begin
        case (cfg.rel)
            REL_EQ:  rel_ok = is_eq;
            REL_NE:  rel_ok = !is_eq;
            REL_LT:  rel_ok = is_lt;
            REL_LE:  rel_ok = is_lt | is_eq;
            REL_GT:  rel_ok = !(is_lt | is_eq);
            REL_GE:  rel_ok = !is_lt;
            default: rel_ok = 1'b0;
        endcase
    end

    // Final gate: armed, strobe present, relation holds.
    always_comb hit = cfg.arm & opnd_vld & rel_ok;

endmodule

// File: rtl/dbg_match_bank.sv
// Module: top of the debug matchpoint bank.
// Instantiates the register file and one comparator per matchpoint,
// and registers the hit vector for one cycle of latency.
module dbg_match_bank
    import dbg_mp_pkg::*;
#(
    parameter int NUM_MP   = 8,
    parameter int DATA_W   = 32,
    parameter int SPR_AW   = 16,
    parameter int REF_BASE = 'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spr_we,
    input  logic [SPR_AW-1:0] spr_addr,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    input  logic [DATA_W-1:0] fetch_addr,
    input  logic              fetch_vld,
    input  logic [DATA_W-1:0] ls_addr,
    input  logic              ls_ld,
    input  logic              ls_st,
    input  logic [DATA_W-1:0] ls_data,
    input  logic              ld_data_vld,
    input  logic              st_data_vld,
    output logic [NUM_MP-1:0] match_o
);
    logic [NUM_MP-1:0][DATA_W-1:0] ref_w;
    mp_cfg_t [NUM_MP-1:0]          cfg_w;
    logic [NUM_MP-1:0]             hit_w;

    dbg_mp_regfile #(
        .NUM_MP(NUM_MP), .DATA_W(DATA_W), .SPR_AW(SPR_AW), .REF_BASE(REF_BASE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
        .ref_q(ref_w), .cfg_q(cfg_w)
    );

    for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
        dbg_mp_compare #(.DATA_W(DATA_W)) cmp_i (
            .cfg(cfg_w[g]), .ref_val(ref_w[g]),
            .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
            .ls_addr(ls_addr), .ls_ld(ls_ld), .ls_st(ls_st),
            .ls_data(ls_data), .ld_data_vld(ld_data_vld), .st_data_vld(st_data_vld),
            .hit(hit_w[g])
        );

        AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_w[g].arm |=> !match_o[g]); // R5
        AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_w[g].rel > REL_GE || cfg_w[g].sel == SRC_NONE) |=> !match_o[g]); // R10
    end

    // Output stage: one-cycle registered match flags.
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= '0;
        else        match_o <= hit_w;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0)); // R1
    AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_vld | ls_ld | ls_st | ld_data_vld | st_data_vld) |=> (match_o == '0)); // R6

endmodule

// File: tb/dbg_match_bank_tb_top.sv
module dbg_match_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NMP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spr_we = 1'b0;
    logic [15:0] spr_addr = '0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata;
    logic [31:0] fetch_addr = '0;
    logic        fetch_vld = 1'b0;
    logic [31:0] ls_addr = '0;
    logic        ls_ld = 1'b0;
    logic        ls_st = 1'b0;
    logic [31:0] ls_data = '0;
    logic        ld_data_vld = 1'b0;
    logic        st_data_vld = 1'b0;
    logic [NMP-1:0] match_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_match_bank dut_i (
        .clk(clk), .rst_n(rst_n), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
        .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
        .ls_addr(ls_addr), .ls_ld(ls_ld), .ls_st(ls_st),
        .ls_data(ls_data), .ld_data_vld(ld_data_vld), .st_data_vld(st_data_vld),
        .match_o(match_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfgw(input bit arm, input int rel, input bit sgn, input int sel);
        return {24'd0, 3'(sel), sgn, 3'(rel), arm};
    endfunction

    function automatic bit rel_holds(input int rel, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        sa = sgn ? longint'($signed(a)) : longint'({32'd0, a});
        sb = sgn ? longint'($signed(b)) : longint'({32'd0, b});
        case (rel)
            0: return sa == sb;
            1: return sa != sb;
            2: return sa <  sb;
            3: return sa <= sb;
            4: return sa >  sb;
            5: return sa >= sb;
            default: return 1'b0;
        endcase
    endfunction

    task automatic spr_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        spr_we = 1'b1; spr_addr = a; spr_wdata = d;
        @(negedge clk);
        spr_we = 1'b0;
    endtask

    task automatic spr_rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        spr_addr = a;
        #1;
        chk(req, spr_rdata, exp);
    endtask

    task automatic obs(input logic [31:0] fa, input bit fv, input logic [31:0] la,
                       input bit ld, input bit st, input logic [31:0] d,
                       input bit dl, input bit ds);
        @(negedge clk);
        fetch_addr = fa; fetch_vld = fv; ls_addr = la; ls_ld = ld; ls_st = st;
        ls_data = d; ld_data_vld = dl; st_data_vld = ds;
    endtask

    task automatic idle();
        obs('0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NMP; i++) spr_wr(16'h3008 + 16'(i), 32'd0);
        idle();
    endtask

    task automatic t_reset();
        spr_rd_chk("R1 ref0", 16'h3000, 32'd0);
        spr_rd_chk("R1 cfg7", 16'h300F, 32'd0);
        chk("R1 match", 32'(match_o), 32'd0);
    endtask

    task automatic t_regs();
        for (int i = 0; i < NMP; i++) spr_wr(16'h3000 + 16'(i), 32'hA5A5_0000 + 32'(i * 17));
        spr_wr(16'h3008, 32'hFFFF_FFE4);
        for (int i = 0; i < NMP; i++)
            spr_rd_chk("R2 ref readback", 16'h3000 + 16'(i), 32'hA5A5_0000 + 32'(i * 17));
        spr_rd_chk("R3 cfg low byte only", 16'h3008, 32'h0000_00E4);
        spr_rd_chk("R3 cfg neighbour untouched", 16'h3009, 32'd0);
        spr_wr(16'h3000, 32'h1234_5678);
        spr_rd_chk("R2 ref write keeps cfg", 16'h3008, 32'h0000_00E4);
        spr_wr(16'h3008, 32'd0);
    endtask

    task automatic t_unmapped();
        spr_wr(16'h3010, 32'hDEAD_BEEF);
        spr_wr(16'h2FFF, 32'hDEAD_BEEF);
        spr_rd_chk("R4 read 0x3010", 16'h3010, 32'd0);
        spr_rd_chk("R4 read 0x2FFF", 16'h2FFF, 32'd0);
        spr_rd_chk("R4 ref7 untouched", 16'h3007, 32'hA5A5_0000 + 32'(7 * 17));
        spr_rd_chk("R4 ref0 untouched", 16'h3000, 32'h1234_5678);
        spr_rd_chk("R4 cfg7 untouched", 16'h300F, 32'd0);
    endtask

    task automatic t_disarmed();
        spr_wr(16'h3000, 32'h0000_0100);
        spr_wr(16'h3008, cfgw(0, 0, 0, 1));
        obs(32'h100, 1, '0, 0, 0, '0, 0, 0);
        @(negedge clk);
        chk("R5 disarmed silent", 32'(match_o), 32'd0);
        clear_cfg();
    endtask

    task automatic t_sources();
        for (int i = 0; i < 7; i++) begin
            spr_wr(16'h3000 + 16'(i), 32'h0000_0040);
            spr_wr(16'h3008 + 16'(i), cfgw(1, 0, 0, i + 1));
        end
        obs(32'h40, 1, 32'h40, 0, 0, 32'h40, 0, 0);
        @(negedge clk);
        chk("R6 fetch only", 32'(match_o), 32'h01);
        obs(32'h40, 0, 32'h40, 1, 0, 32'h40, 0, 0);
        @(negedge clk);
        chk("R6 load addr", 32'(match_o), 32'h0A);
        obs(32'h40, 0, 32'h40, 0, 1, 32'h40, 0, 0);
        @(negedge clk);
        chk("R6 store addr", 32'(match_o), 32'h0C);
        obs(32'h40, 0, 32'h40, 0, 0, 32'h40, 1, 0);
        @(negedge clk);
        chk("R6 load data", 32'(match_o), 32'h50);
        obs(32'h40, 0, 32'h40, 0, 0, 32'h40, 0, 1);
        @(negedge clk);
        chk("R6 store data", 32'(match_o), 32'h60);
        obs(32'h40, 0, 32'h40, 0, 0, 32'h40, 0, 0);
        @(negedge clk);
        chk("R6 no strobe", 32'(match_o), 32'h00);
        obs(32'h41, 1, 32'h40, 1, 1, 32'h41, 1, 1);
        @(negedge clk);
        chk("R6 value per source", 32'(match_o), 32'h0E);
        clear_cfg();
    endtask

    task automatic t_relations(input bit sgn, input logic [31:0] refv, input logic [31:0] op);
        logic [31:0] exp;
        exp = '0;
        for (int r = 0; r < 6; r++) begin
            spr_wr(16'h3000 + 16'(r), refv);
            spr_wr(16'h3008 + 16'(r), cfgw(1, r, sgn, 1));
            exp[r] = rel_holds(r, sgn, op, refv);
        end
        obs(op, 1, '0, 0, 0, '0, 0, 0);
        @(negedge clk);
        if (sgn) chk("R8 signed relations", 32'(match_o), exp);
        else     chk("R7 unsigned relations", 32'(match_o), exp);
        clear_cfg();
    endtask

    task automatic t_latency();
        spr_wr(16'h3000, 32'h0000_0200);
        spr_wr(16'h3008, cfgw(1, 0, 0, 1));
        obs(32'h200, 1, '0, 0, 0, '0, 0, 0);
        #1;
        chk("R9 not combinational", 32'(match_o), 32'd0);
        @(negedge clk);
        chk("R9 after one edge", 32'(match_o), 32'h01);
        idle();
        @(negedge clk);
        chk("R9 drops", 32'(match_o), 32'd0);
        clear_cfg();
    endtask

    task automatic t_reserved();
        spr_wr(16'h3000, 32'h0000_0300);
        spr_wr(16'h3008, cfgw(1, 6, 0, 1));
        spr_wr(16'h3001, 32'h0000_0300);
        spr_wr(16'h3009, cfgw(1, 7, 1, 1));
        spr_wr(16'h3002, 32'h0000_0300);
        spr_wr(16'h300A, cfgw(1, 0, 0, 0));
        obs(32'h300, 1, 32'h300, 1, 1, 32'h300, 1, 1);
        @(negedge clk);
        chk("R10 reserved codes silent", 32'(match_o), 32'd0);
        clear_cfg();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unmapped();
        t_disarmed();
        t_sources();
        t_relations(0, 32'h0000_0080, 32'h0000_007F);
        t_relations(0, 32'h0000_0080, 32'h0000_0080);
        t_relations(0, 32'h0000_0080, 32'h0000_0081);
        t_relations(0, 32'h0000_0010, 32'hFFFF_FFF0);
        t_relations(1, 32'h0000_0010, 32'hFFFF_FFF0);
        t_relations(1, 32'hFFFF_FFF0, 32'h0000_0010);
        t_relations(1, 32'h8000_0000, 32'h8000_0000);
        t_latency();
        t_reserved();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule